// File: doc/BRIEF.md
# SPI Master Transmit Path with Per-Word Control

This block is the transmit side of an SPI master in which every word handed to it may bring its own framing controls: the frame length and the slave-select pattern. Software reaches it through one write port with three modes. A combined write delivers data and control together. A data-only write sends data under the control value already held. A control-only write changes the held control value without sending anything. The combined write and the control-only write update the same shared control storage.

One holding slot keeps a pending word together with the control it was written with. When the shift engine picks that word up, it copies the frame length and the select pattern into its own latch. A new length therefore has no effect until a word is actually sent with it. Receive data is gathered with that latched length, since no separate receive length exists. Data leaves MSB first in SPI mode 0. Four select outputs follow the latched pattern, and each has its own polarity setting. If the next word is already waiting when a frame ends, the engine starts it in the same cycle, so the selects stay asserted across the words of a long transfer.

Top module: `spi_ctl_master`

## Requirements
- R1: After reset `tx_ready` is 1, `rx_valid` is 0, `sclk` is 0, and every select pin sits at its inactive level `~sel_inv[i]`.
- R2: A write with `wr_mode`=0 sends `wr_word[15:0]` as data. Bits 19:16 are per-select controls for selects 0 to 3: 0 asserts that select and 1 leaves it deasserted. Bits 27:24 give the frame length minus one. Data is shifted out MSB first in SPI mode 0: `sclk` idles low, `mosi` changes on the falling edge, and `miso` is sampled on the rising edge.
- R3: A write with `wr_mode`=1 sends `wr_word[15:0]` using the shared control value as it stands, with the length and select pattern of the last control written.
- R4: A write with `wr_mode`=2 loads `wr_word[27:16]` into the shared control value and starts no frame. A `wr_mode`=0 write loads the same storage. `wr_mode`=3 has no effect.
- R5: The frame length and select pattern take effect when a word starts shifting. A control change made afterwards does not alter a frame already sent or received.
- R6: At the end of a frame, `rx_data` holds the received bits right-aligned with zeros above them, and `rx_valid` goes to 1. A pulse on `rx_rd` clears `rx_valid`.
- R7: When `sel_inv[i]`=1, select pin i is active high. When it is 0, the pin is active low.
- R8: `tx_ready` is 0 while the holding slot is full. A data-carrying write (`wr_mode` 0 or 1) made while the slot is full is ignored.
- R9: When a word is waiting at the end of a frame, the next frame starts at once. A select that both words assert stays asserted between them.
- R10: A frame with length field L produces exactly L+1 rising edges on `sclk`, for every L from 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_mode | input | 2 | 0 data+control, 1 data only, 2 control only, 3 none |
| wr_word | input | 28 | Written word: data in 15:0, control in 27:16 |
| sel_inv | input | 4 | Per-select polarity: 1 makes that pin active high |
| rx_rd | input | 1 | Clears `rx_valid` |
| miso | input | 1 | Serial data in |
| tx_ready | output | 1 | Holding slot can accept a data write |
| rx_data | output | 16 | Last received frame, right-aligned |
| rx_valid | output | 1 | A received frame is waiting |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| ssel_o | output | 4 | Slave-select pins |

## Verification
Assertions check several properties on every cycle: that a full holding slot drops data writes, that the latched length and pattern stay fixed during a frame, that the bit counter never passes the latched length, that `mosi` is steady while `sclk` is high, and that idle select pins sit at their inactive level. Other behaviours can only be shown by the bench, with `mosi` looped back to `miso`. These are the received values for lengths 1, 8 and 16, the bit order, the pin patterns under each polarity setting, a length change that waits for the next transmit, and selects that stay asserted across back-to-back words.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
    localparam int DATA_W = 16;
    localparam int NSEL   = 4;
    localparam int LEN_W  = $clog2(DATA_W);
    localparam int CTL_W  = 12;
    localparam int WORD_W = DATA_W + CTL_W;

    typedef enum logic [1:0] {
        WM_BOTH = 2'd0,
        WM_DATA = 2'd1,
        WM_CTL  = 2'd2,
        WM_NONE = 2'd3
    } wr_mode_e;

    // Layout matches bits 27:16 of the written word.
    typedef struct packed {
        logic [LEN_W-1:0]            len_m1;
        logic [CTL_W-LEN_W-NSEL-1:0] spare;
        logic [NSEL-1:0]             ssel_n;
    } ctl_t;
endpackage

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs
    import spi_ctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_mode,
    input  logic [WORD_W-1:0]    wr_word,
    input  logic                 take,
    output logic                 hold_v,
    output logic [DATA_W-1:0]    hold_data,
    output ctl_t                 hold_ctl
);
    typedef struct packed {
        ctl_t              shared;
        logic              hold_v;
        logic [DATA_W-1:0] hold_data;
        ctl_t              hold_ctl;
    } regs_t;

    regs_t q, d;
    ctl_t  new_ctl;

    always_comb begin
        new_ctl = ctl_t'(wr_word[WORD_W-1:DATA_W]);
        d = q;
        if (take) d.hold_v = 1'b0;
        if (wr_en) begin
            unique case (wr_mode_e'(wr_mode))
                WM_BOTH: if (!q.hold_v) begin
                    d.shared    = new_ctl;
                    d.hold_v    = 1'b1;
                    d.hold_data = wr_word[DATA_W-1:0];
                    d.hold_ctl  = new_ctl;
                end
                WM_DATA: if (!q.hold_v) begin
                    d.hold_v    = 1'b1;
                    d.hold_data = wr_word[DATA_W-1:0];
                    d.hold_ctl  = q.shared;
                end
                WM_CTL:  d.shared = new_ctl;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hold_v    = q.hold_v;
    assign hold_data = q.hold_data;
    assign hold_ctl  = q.hold_ctl;

    // R8: a data write into a full slot leaves the pending word untouched
    p_full_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_mode == 2'd0 || wr_mode == 2'd1) && hold_v && !take)
        |=> (hold_v && $stable(hold_data) && $stable(hold_ctl)));

    // R4: a control-only write never fills the slot
    p_ctl_no_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == 2'd2 && !hold_v) |=> !hold_v);
endmodule

// File: rtl/spi_ctl_shifter.sv
module spi_ctl_shifter
    import spi_ctl_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_v,
    input  logic [DATA_W-1:0] hold_data,
    input  ctl_t              hold_ctl,
    input  logic              miso,
    input  logic              rx_rd,
    output logic              take,
    output logic              busy,
    output logic [NSEL-1:0]   ssel_n,
    output logic              sclk,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);
    localparam int CW = $clog2(DIV_HALF + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(DIV_HALF - 1);

    typedef struct packed {
        logic              busy;
        logic              phase;
        logic [CW-1:0]     cnt;
        logic [LEN_W-1:0]  bitcnt;
        logic [LEN_W-1:0]  len_m1;
        logic [NSEL-1:0]   ssel_n;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_sh;
        logic [DATA_W-1:0] rx_data;
        logic              rx_valid;
    } sh_t;

    sh_t  q, d;
    logic done;
    logic unused_spare;

    assign unused_spare = ^hold_ctl.spare;

    always_comb begin
        d    = q;
        take = 1'b0;
        done = 1'b0;
        if (rx_rd) d.rx_valid = 1'b0;
        if (q.busy) begin
            if (q.cnt == CNT_TOP) begin
                d.cnt = '0;
                if (!q.phase) begin
                    d.phase = 1'b1;
                    d.rx_sh = {q.rx_sh[DATA_W-2:0], miso};
                end else begin
                    d.phase = 1'b0;
                    if (q.bitcnt == q.len_m1) begin
                        done       = 1'b1;
                        d.busy     = 1'b0;
                        d.rx_data  = q.rx_sh;
                        d.rx_valid = 1'b1;
                    end else begin
                        d.bitcnt = q.bitcnt + 1'b1;
                        d.tx_sh  = {q.tx_sh[DATA_W-2:0], 1'b0};
                    end
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
        if (hold_v && (!q.busy || done)) begin
            take     = 1'b1;
            d.busy   = 1'b1;
            d.phase  = 1'b0;
            d.cnt    = '0;
            d.bitcnt = '0;
            d.len_m1 = hold_ctl.len_m1;
            d.ssel_n = hold_ctl.ssel_n;
            d.tx_sh  = hold_data << (LEN_W'(DATA_W - 1) - hold_ctl.len_m1);
            d.rx_sh  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.busy;
    assign ssel_n   = q.ssel_n;
    assign sclk     = q.busy & q.phase;
    assign mosi     = q.tx_sh[DATA_W-1];
    assign rx_data  = q.rx_data;
    assign rx_valid = q.rx_valid;

    // R5: length and pattern hold still for the whole frame
    p_ctl_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !take) |=> ($stable(q.len_m1) && $stable(q.ssel_n)));

    // R10: the bit counter never runs past the latched length
    p_bit_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.bitcnt <= q.len_m1));

    // R2: mosi does not move while sclk is high
    p_mosi_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R6: a new frame result appears only right after a high sclk phase
    p_valid_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(sclk));
endmodule

// File: rtl/spi_ctl_ssel.sv
module spi_ctl_ssel
    import spi_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy,
    input  logic [NSEL-1:0] ssel_n,
    input  logic [NSEL-1:0] sel_inv,
    output logic [NSEL-1:0] ssel_o
);
    for (genvar i = 0; i < NSEL; i++) begin : g_pin
        logic active;
        assign active    = busy & ~ssel_n[i];
        assign ssel_o[i] = active ? sel_inv[i] : ~sel_inv[i];
    end

    // R1 R7: with no frame running every pin sits at its inactive level
    p_idle_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ssel_o == ~sel_inv));
endmodule

// File: rtl/spi_ctl_master.sv
module spi_ctl_master
    import spi_ctl_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_mode,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [NSEL-1:0]   sel_inv,
    input  logic              rx_rd,
    input  logic              miso,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sclk,
    output logic              mosi,
    output logic [NSEL-1:0]   ssel_o
);
    logic              hold_v, take, busy;
    logic [DATA_W-1:0] hold_data;
    ctl_t              hold_ctl;
    logic [NSEL-1:0]   lat_ssel_n;

    spi_ctl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode),
        .wr_word(wr_word), .take(take), .hold_v(hold_v),
        .hold_data(hold_data), .hold_ctl(hold_ctl)
    );

    spi_ctl_shifter #(.DIV_HALF(DIV_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .hold_v(hold_v), .hold_data(hold_data),
        .hold_ctl(hold_ctl), .miso(miso), .rx_rd(rx_rd), .take(take),
        .busy(busy), .ssel_n(lat_ssel_n), .sclk(sclk), .mosi(mosi),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    spi_ctl_ssel u_ssel (
        .clk(clk), .rst_n(rst_n), .busy(busy), .ssel_n(lat_ssel_n),
        .sel_inv(sel_inv), .ssel_o(ssel_o)
    );

    assign tx_ready = ~hold_v;

    // R8: the slot is taken only when it holds a word
    p_take_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !tx_ready);
endmodule

// File: tb/spi_ctl_master_tb.sv
module spi_ctl_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_mode = 2'd3;
    logic [27:0] wr_word = '0;
    logic [3:0]  sel_inv = 4'h0;
    logic        rx_rd = 1'b0;
    logic        tx_ready, rx_valid, sclk, mosi;
    logic [15:0] rx_data;
    logic [3:0]  ssel_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spi_ctl_master #(.DIV_HALF(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode),
        .wr_word(wr_word), .sel_inv(sel_inv), .rx_rd(rx_rd), .miso(mosi),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .sclk(sclk), .mosi(mosi), .ssel_o(ssel_o)
    );

    // monitor, sampled away from the active edge
    int         rises = 0;
    int         pin_chg = 0;
    logic       sclk_prev = 1'b0;
    logic [3:0] pins_prev = 4'hF;
    logic [3:0] pat_seen = 4'h0;
    always @(negedge clk) begin
        if (sclk && !sclk_prev) rises++;
        if (sclk) pat_seen = ssel_o;
        if (ssel_o != pins_prev) pin_chg++;
        sclk_prev = sclk;
        pins_prev = ssel_o;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] m, input logic [27:0] w);
        wr_en = 1'b1; wr_mode = m; wr_word = w;
        @(negedge clk);
        wr_en = 1'b0; wr_mode = 2'd3;
    endtask

    task automatic rd();
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic wait_valid(input string req);
        for (int i = 0; i < 2000; i++) begin
            if (rx_valid) break;
            @(negedge clk);
        end
        chk(req, {31'd0, rx_valid}, 32'd1);
    endtask

    function automatic logic [27:0] mk(input logic [3:0] l, input logic [3:0] s, input logic [15:0] dt);
        return {l, 4'h0, s, dt};
    endfunction

    // data, length-1, select controls, polarity
    typedef struct packed {
        logic [15:0] dat;
        logic [3:0]  len_m1;
        logic [3:0]  sn;
        logic [3:0]  inv;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'h0001, 4'd0,  4'b1110, 4'b0000},
        '{16'hFFFE, 4'd0,  4'b1101, 4'b0000},
        '{16'h12A5, 4'd7,  4'b1011, 4'b0000},
        '{16'hC3A9, 4'd15, 4'b0111, 4'b0000},
        '{16'h8001, 4'd15, 4'b1100, 4'b0101},
        '{16'h0F6D, 4'd7,  4'b1110, 4'b0000}
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_ready", {31'd0, tx_ready}, 32'd1);
        chk("R1 rx_valid", {31'd0, rx_valid}, 32'd0);
        chk("R1 sclk", {31'd0, sclk}, 32'd0);
        chk("R1 pins", {28'd0, ssel_o}, 32'hF);

        // R2 R6 R7 R10 table of combined writes, looped back
        for (int v = 0; v < 6; v++) begin
            logic [15:0] mask;
            sel_inv = VECS[v].inv;
            @(negedge clk);
            rises = 0;
            mask = 16'((32'd1 << (VECS[v].len_m1 + 1)) - 1);
            wr(2'd0, mk(VECS[v].len_m1, VECS[v].sn, VECS[v].dat));
            wait_valid("R6 valid");
            chk("R2 R6 rx_data", {16'd0, rx_data}, {16'd0, VECS[v].dat & mask});
            chk("R10 edges", rises, VECS[v].len_m1 + 1);
            chk("R2 R7 pattern", {28'd0, pat_seen}, {28'd0, VECS[v].sn ^ VECS[v].inv});
            chk("R7 idle pins", {28'd0, ssel_o}, {28'd0, ~VECS[v].inv});
            rd();
            chk("R6 rx_rd clears", {31'd0, rx_valid}, 32'd0);
        end

        // R3 data-only write reuses length 8 and pattern 1110
        rises = 0;
        wr(2'd1, {12'hFFF, 16'h33A5});
        wait_valid("R3 valid");
        chk("R3 rx_data", {16'd0, rx_data}, 32'hA5);
        chk("R3 edges", rises, 8);
        chk("R3 pattern", {28'd0, pat_seen}, 32'hE);
        rd();

        // R4 R5 control-only write: no frame, old result unchanged
        rises = 0;
        wr(2'd2, mk(4'd15, 4'b0111, 16'h1234));
        repeat (40) @(negedge clk);
        chk("R4 no frame edges", rises, 0);
        chk("R4 no valid", {31'd0, rx_valid}, 32'd0);
        chk("R4 pins idle", {28'd0, ssel_o}, 32'hF);
        chk("R5 old rx kept", {16'd0, rx_data}, 32'hA5);
        wr(2'd3, mk(4'd3, 4'b0000, 16'hFFFF));
        repeat (20) @(negedge clk);
        chk("R4 mode3 no frame", rises, 0);
        wr(2'd1, 28'h000BEEF);
        wait_valid("R5 valid");
        chk("R5 new length rx", {16'd0, rx_data}, 32'hBEEF);
        chk("R5 new length edges", rises, 16);
        chk("R5 new pattern", {28'd0, pat_seen}, 32'h7);
        rd();

        // R8 R9 full slot and back-to-back words
        @(negedge clk);
        pin_chg = 0;
        wr(2'd0, mk(4'd15, 4'b1010, 16'h9C35));
        @(negedge clk);
        chk("R8 ready after take", {31'd0, tx_ready}, 32'd1);
        wr(2'd0, mk(4'd7, 4'b1010, 16'h003C));
        chk("R8 full not ready", {31'd0, tx_ready}, 32'd0);
        wr(2'd1, 28'h0000055);
        wr(2'd0, mk(4'd3, 4'b0000, 16'h000F));
        wait_valid("R9 first valid");
        chk("R9 first rx", {16'd0, rx_data}, 32'h9C35);
        rd();
        wait_valid("R9 second valid");
        chk("R8 second rx", {16'd0, rx_data}, 32'h3C);
        rd();
        repeat (100) @(negedge clk);
        chk("R8 ignored write sent nothing", {31'd0, rx_valid}, 32'd0);
        chk("R9 pins changed twice", pin_chg, 2);
        chk("R9 pattern", {28'd0, pat_seen}, 32'hA);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule